// File: doc/BRIEF.md
# Vectored Interrupt Flag Controller

This block keeps the interrupt status and enable byte of a small microcontroller core. Three dedicated sources feed it: a selectable edge on an external interrupt pin, a selectable edge on a timer clock pin, and a one-cycle timer overflow pulse. A fourth, combined request summarises a bank of peripheral flags, each gated by its own enable. The block records events in flag bits and masks them with enable bits. It then picks the most urgent pending source and offers the core a fixed vector address through a request/acknowledge handshake.

When the core acknowledges a request, the block commits the vector. On that same clock edge it clears the flag of the dedicated source it served. The peripheral summary bit is never stored. It follows the external peripheral flag and enable vectors, which the block never clears. The core reads the whole byte and writes its seven lower bits through a simple register port.

Top module: `intc_vector_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00, `vec_req` is 0 and `vec_addr` is 0x00.
- R2: Bits 6..0 are written by `reg_wr_en`/`reg_wdata` and read back unchanged on `reg_rdata`. The layout is: bit 0 external-pin enable, bit 1 overflow enable, bit 2 timer-pin enable, bit 3 peripheral group enable, bit 4 external-pin flag, bit 5 overflow flag, bit 6 timer-pin flag.
- R3: Bit 7 reads as the OR over all peripheral sources of (flag AND enable). Writes do not change it, and neither does bit 3.
- R4: Each pin passes through a two-flop synchronizer. Its edge select input chooses a rising edge when 1 and a falling edge when 0. A selected edge that arrives between clock edges makes the pin's flag read 1 after the third rising clock edge. The opposite edge sets nothing.
- R5: A one-cycle high on `tmr_ovf_pulse` sets bit 5 at the next rising edge.
- R6: A dedicated source is pending when both its flag and its enable are 1. The peripheral group is pending when bit 7 and bit 3 are both 1.
- R7: `vec_req` is 1 only when `glb_int_en` is 1 and at least one source is pending. While `vec_req` is 0, `vec_addr` is 0x00.
- R8: Priority order is external pin (vector 0x08), then overflow (0x10), then timer pin (0x18), then peripheral group (0x20).
- R9: An edge where `vec_ack` and `vec_req` are both 1 clears the flag of the dedicated source being served, and only that flag. Serving the peripheral group clears nothing.
- R10: A hardware set of a flag wins over a software write of 0 to that flag, and over an acknowledge clear of that flag, in the same cycle.
- R11: `vec_ack` while `vec_req` is 0 changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the status byte |
| reg_wdata | input | 8 | Write data (bit 7 ignored) |
| reg_rdata | output | 8 | Current status byte |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_rise_sel | input | 1 | 1: rising edge, 0: falling edge for `ext_pin` |
| tmr_pin | input | 1 | Timer clock pin (asynchronous) |
| tmr_rise_sel | input | 1 | 1: rising edge, 0: falling edge for `tmr_pin` |
| tmr_ovf_pulse | input | 1 | Timer overflow strobe |
| periph_flags | input | NUM_PERIPH | Peripheral flag bank |
| periph_enables | input | NUM_PERIPH | Peripheral enable bank |
| glb_int_en | input | 1 | Global interrupt enable from the core |
| vec_ack | input | 1 | Core accepts the offered vector |
| vec_req | output | 1 | Interrupt request to the core |
| vec_addr | output | 8 | Vector address of the served source |

## Verification
The bench builds the block with its default parameters: eight peripheral sources and a two-stage synchronizer. With these values the three-edge pin latency can be checked exactly. Any single peripheral bit is enough to drive the summary and the lowest-priority vector. Stimulus sets all four sources at once to step through the priority chain, and lines up hardware sets with software writes and acknowledges in one cycle to reach the collision rules.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int NUM_SRC     = 4;
  localparam int NUM_DED     = 3;
  localparam int REG_W       = 8;
  localparam int RW_W        = REG_W - 1;
  localparam int FLAG_BASE   = 4;
  localparam int PERI_EN_BIT = 3;
  localparam int SUMMARY_BIT = 7;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_TOVF = 2'd1,
    SRC_TPIN = 2'd2,
    SRC_PERI = 2'd3
  } src_e;

  // vector = (source index + 1) * 8
  function automatic logic [7:0] vector_of(input logic [1:0] idx);
    return {3'b000, idx, 3'b000} + 8'd8;
  endfunction

  function automatic logic edge_hit(input logic rising, input logic cur, input logic prev);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

  // lowest index wins
  function automatic logic [1:0] first_set(input logic [NUM_SRC-1:0] v);
    logic [1:0] r;
    r = 2'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = 2'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  import intc_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              synced;

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= synced;
    end
  end

  assign hit = edge_hit(rise_sel, synced, prev_q);

  // R4: same edge kind cannot hit twice in a row
  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $stable(rise_sel)) |=> (!hit || (rise_sel != $past(rise_sel))));

endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank
  import intc_pkg::*;
#(
  parameter int W    = RW_W,
  parameter int NDED = NUM_DED
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [W-1:0]    wdata,
  input  logic [NDED-1:0] hw_set,
  input  logic [NDED-1:0] hw_clr,
  output logic [W-1:0]    bits_q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= FLAG_BASE && i < FLAG_BASE + NDED) begin : g_flag
      localparam int S = i - FLAG_BASE;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             bits_q[i] <= 1'b0;
        else if (hw_set[S])     bits_q[i] <= 1'b1;
        else if (hw_clr[S])     bits_q[i] <= 1'b0;
        else if (wr_en)         bits_q[i] <= wdata[i];
      end

      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[S] |=> bits_q[i]);
      assert_taken_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr[S] && !hw_set[S]) |=> !bits_q[i]);
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bits_q[i] <= 1'b0;
        else if (wr_en)  bits_q[i] <= wdata[i];
      end
    end
  end

endmodule

// File: rtl/intc_vector_sel.sv
module intc_vector_sel
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               glb_en,
  output logic               req,
  output logic [NUM_SRC-1:0] grant,
  output logic [7:0]         addr
);

  logic [1:0] win_idx;
  logic       any_pend;

  assign any_pend = |pend;
  assign win_idx  = first_set(pend);
  assign req      = glb_en & any_pend;

  always_comb begin
    grant = '0;
    if (any_pend) grant[win_idx] = 1'b1;
  end

  assign addr = req ? vector_of(win_idx) : 8'h00;

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);
  assert_idle_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (addr == 8'h00));

endmodule

// File: rtl/intc_vector_ctrl.sv
module intc_vector_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_PERIPH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  ext_pin,
  input  logic                  ext_rise_sel,
  input  logic                  tmr_pin,
  input  logic                  tmr_rise_sel,
  input  logic                  tmr_ovf_pulse,
  input  logic [NUM_PERIPH-1:0] periph_flags,
  input  logic [NUM_PERIPH-1:0] periph_enables,
  input  logic                  glb_int_en,
  input  logic                  vec_ack,
  output logic                  vec_req,
  output logic [7:0]            vec_addr
);

  logic [RW_W-1:0]    rw_bits;
  logic               peri_summary;
  logic               ext_hit;
  logic               tpin_hit;
  logic [NUM_DED-1:0] hw_set;
  logic [NUM_DED-1:0] hw_clr;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic               take;

  intc_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(ext_rise_sel), .hit(ext_hit)
  );

  intc_edge_sync #(.STAGES(SYNC_STAGES)) u_tpin_sync (
    .clk(clk), .rst_n(rst_n), .pin(tmr_pin), .rise_sel(tmr_rise_sel), .hit(tpin_hit)
  );

  assign hw_set[SRC_EXT]  = ext_hit;
  assign hw_set[SRC_TOVF] = tmr_ovf_pulse;
  assign hw_set[SRC_TPIN] = tpin_hit;

  assign take = vec_ack & vec_req;

  for (genvar s = 0; s < NUM_DED; s++) begin : g_ded
    assign pend[s]   = rw_bits[FLAG_BASE + s] & rw_bits[s];
    assign hw_clr[s] = take & grant[s];
  end

  assign peri_summary   = |(periph_flags & periph_enables);
  assign pend[SRC_PERI] = peri_summary & rw_bits[PERI_EN_BIT];

  intc_flag_bank #(.W(RW_W), .NDED(NUM_DED)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wdata(reg_wdata[RW_W-1:0]),
    .hw_set(hw_set), .hw_clr(hw_clr),
    .bits_q(rw_bits)
  );

  intc_vector_sel u_sel (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .glb_en(glb_int_en),
    .req(vec_req), .grant(grant), .addr(vec_addr)
  );

  assign reg_rdata = {peri_summary, rw_bits};

  assert_req_needs_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> glb_int_en);
  assert_ack_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !vec_req && !reg_wr_en && (hw_set == '0)) |=> $stable(rw_bits));
  assert_ext_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == 8'h08 && !ext_hit) |=> !rw_bits[FLAG_BASE]);

endmodule

// File: tb/tb_intc_vector_ctrl.sv
module tb_intc_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic ext_pin = 0, ext_rise_sel = 1, tmr_pin = 0, tmr_rise_sel = 1, tmr_ovf_pulse = 0;
  logic [NP-1:0] periph_flags = 0, periph_enables = 0;
  logic glb_int_en = 0, vec_ack = 0;
  logic vec_req;
  logic [7:0] vec_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_vector_ctrl #(.NUM_PERIPH(NP), .SYNC_STAGES(2)) dut (.*);

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr_en = 1; reg_wdata = v; tick();
    reg_wr_en = 0;
  endtask

  task automatic ack();
    vec_ack = 1; tick();
    vec_ack = 0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 req", {7'd0, vec_req}, 8'h00);
    check("R1 addr", vec_addr, 8'h00);
  endtask

  task automatic t_rw();
    wr(8'hFF); check("R2/R3 write ff", reg_rdata, 8'h7F);
    wr(8'h55); check("R2 write 55", reg_rdata, 8'h55);
    wr(8'h2A); check("R2 write 2a", reg_rdata, 8'h2A);
    wr(8'h00); check("R2 write 00", reg_rdata, 8'h00);
  endtask

  task automatic t_summary();
    glb_int_en = 1;
    periph_flags = 8'h04; tick();
    check("R3 flag no enable", reg_rdata, 8'h00);
    periph_enables = 8'h04; tick();
    check("R3 summary set", reg_rdata, 8'h80);
    check("R6 no group enable", {7'd0, vec_req}, 8'h00);
    wr(8'h08);
    check("R6 group pending", {7'd0, vec_req}, 8'h01);
    check("R8 peripheral vector", vec_addr, 8'h20);
    wr(8'h00);
    check("R3 write ignores bit7", reg_rdata, 8'h80);
    wr(8'h08); ack();
    check("R9 summary not cleared", reg_rdata, 8'h88);
    periph_flags = 8'h00; tick();
    check("R3 summary drops", reg_rdata, 8'h08);
    check("R7 no pending no req", {7'd0, vec_req}, 8'h00);
    periph_enables = 0; glb_int_en = 0; wr(8'h00);
  endtask

  task automatic t_tovf();
    tmr_ovf_pulse = 1; tick(); tmr_ovf_pulse = 0;
    check("R5 overflow flag", reg_rdata, 8'h20);
    wr(8'h22); glb_int_en = 1; tick();
    check("R8 overflow vector", vec_addr, 8'h10);
    ack();
    check("R9 overflow cleared", reg_rdata, 8'h02);
    check("R7 req after clear", {7'd0, vec_req}, 8'h00);
    glb_int_en = 0; wr(8'h00);
  endtask

  task automatic t_pins();
    ext_rise_sel = 1; ext_pin = 1; tick(2);
    check("R4 ext not yet", reg_rdata, 8'h00);
    tick();
    check("R4 ext rising", reg_rdata, 8'h10);
    wr(8'h00);
    ext_pin = 0; tick(5);
    check("R4 ext falling ignored", reg_rdata, 8'h00);
    tmr_rise_sel = 0; tmr_pin = 1; tick(5);
    check("R4 tpin rising ignored", reg_rdata, 8'h00);
    tmr_pin = 0; tick(2);
    check("R4 tpin not yet", reg_rdata, 8'h00);
    tick();
    check("R4 tpin falling", reg_rdata, 8'h40);
    wr(8'h00);
  endtask

  task automatic t_priority();
    periph_flags = 8'h01; periph_enables = 8'h01; glb_int_en = 1;
    wr(8'h7F);
    check("R8 all pending", reg_rdata, 8'hFF);
    check("R8 ext first", vec_addr, 8'h08);
    ack(); check("R9 ext cleared", reg_rdata, 8'hEF);
    check("R8 overflow second", vec_addr, 8'h10);
    ack(); check("R9 ovf cleared", reg_rdata, 8'hCF);
    check("R8 tpin third", vec_addr, 8'h18);
    ack(); check("R9 tpin cleared", reg_rdata, 8'h8F);
    check("R8 peripheral last", vec_addr, 8'h20);
    ack(); check("R9 peripheral untouched", reg_rdata, 8'h8F);
    glb_int_en = 0; tick();
    check("R7 gie low req", {7'd0, vec_req}, 8'h00);
    check("R7 gie low addr", vec_addr, 8'h00);
    periph_flags = 0; periph_enables = 0; wr(8'h00);
  endtask

  task automatic t_collide();
    reg_wr_en = 1; reg_wdata = 8'h00; tmr_ovf_pulse = 1; tick();
    reg_wr_en = 0; tmr_ovf_pulse = 0;
    check("R10 set beats write0", reg_rdata, 8'h20);
    wr(8'h22);
    ack();
    check("R11 ack without req", reg_rdata, 8'h22);
    glb_int_en = 1; tick();
    vec_ack = 1; tmr_ovf_pulse = 1; tick();
    vec_ack = 0; tmr_ovf_pulse = 0;
    check("R10 set beats ack clear", reg_rdata, 8'h22);
    ack();
    check("R9 later ack clears", reg_rdata, 8'h02);
    glb_int_en = 0; wr(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2); rst_n = 1; tick();
    t_reset();
    t_rw();
    t_summary();
    t_tovf();
    t_pins();
    t_priority();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule